// File: doc/BRIEF.md
# Packet playout start gate

This block sits beside the packet store of one video channel and decides when playout may begin. It keeps a running count of the packets that are currently held downstream. Each arrival pulse raises the count and each consumption pulse lowers it. Output stays held back until the count has reached a software-set start threshold, so the threshold sets the start-up latency in packets. Once that level is reached, a run indication is raised and consumption is honoured. If the store drains empty, the gate falls back to waiting and must refill to the threshold before it releases again.

Beside the gate, a frame checker counts the arrivals between consecutive frame-start pulses. It compares each closed frame's count with an expected packets-per-frame value. Any mismatch raises an error flag that stays set until reset. The packet memory and the video formatting are outside this block.

Top module: `pgate_top`

## Requirements
- R1: After reset, `buffered` is 0, `run` is 0 and `frame_err` is 0.
- R2: An arrival pulse without an honoured consumption raises `buffered` by one on the next clock edge, saturating at all ones (0xFFFF at the default width). An honoured consumption without an arrival lowers it by one, saturating at 0.
- R3: While `chan_en` is 1 and the gate is waiting, `run` rises on the clock edge after the one at which `buffered` (zero-extended) became greater than or equal to `start_thresh`. With a threshold of 0, `run` rises on the first edge with `chan_en` high. Threshold bits above the count width take part in the comparison.
- R4: When an arrival and an honoured consumption fall in the same cycle, `buffered` is unchanged.
- R5: A consumption pulse while `run` is 0 is ignored: `buffered` does not decrease.
- R6: When an honoured consumption empties the count (from 1 to 0 with no arrival), `run` falls on that same edge, and the gate releases again only on reaching the threshold once more.
- R7: Dropping `chan_en` while running clears `run` on the next edge, and the count is kept.
- R8: On a `frame_start` pulse, the number of arrivals since the previous `frame_start` is compared with `frame_expect`, and a mismatch sets `frame_err` on that edge. The first `frame_start` after reset only opens a frame and checks nothing. An arrival in the same cycle as `frame_start` belongs to the new frame.
- R9: `frame_err` stays at 1 once set, whatever the later frames contain, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; release is only allowed while high |
| start_thresh | input | THR_W (32) | Packets to accumulate before playout starts |
| frame_expect | input | FRM_W (16) | Expected arrivals per frame |
| pkt_arrive | input | 1 | One-cycle pulse per packet stored |
| pkt_consume | input | 1 | One-cycle pulse per packet read for output |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| buffered | output | CNT_W (16) | Current count of held packets |
| run | output | 1 | Playout released |
| frame_err | output | 1 | Sticky per-frame count mismatch |

## Verification
The assertions assume that each pulse input is a level sampled once per clock: one cycle high stands for exactly one event. They also assume that `start_thresh` and `frame_expect` only move between the events they govern, because release and frame checks are judged against the previous cycle's values. The bench drives every input on the falling edge. It changes thresholds and expected counts only while the channel is in reset or disabled, and it sweeps thresholds 0 to 8 and frame-count pairs 0 to 3 inside these assumptions.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
   typedef enum logic [0:0] {
      GATE_WAIT = 1'b0,
      GATE_RUN  = 1'b1
   } gate_state_e;
endpackage

// File: rtl/pgate_occ.sv
// Saturating occupancy counter of held packets.
module pgate_occ #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             drain
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic up, down;
   assign up    = inc && !dec && (count != CNT_MAX);
   assign down  = dec && !inc && (count != '0);
   assign drain = dec && !inc && (count == CNT_ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (up)   count <= count + CNT_ONE;
      else if (down) count <= count - CNT_ONE;
   end
endmodule

// File: rtl/pgate_fsm.sv
// Wait/run gate: releases once the count meets the threshold.
module pgate_fsm
   import pgate_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int THR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic [THR_W-1:0] thresh,
   input  logic [CNT_W-1:0] count,
   input  logic             drain,
   output logic             run
);
   logic        reach;
   gate_state_e state;

   generate
      if (THR_W > CNT_W) begin : g_wide_thr
         assign reach = (thresh[THR_W-1:CNT_W] == '0) &&
                        (count >= thresh[CNT_W-1:0]);
      end else if (THR_W == CNT_W) begin : g_same_thr
         assign reach = (count >= thresh);
      end else begin : g_narrow_thr
         assign reach = (count[CNT_W-1:THR_W] != '0) ||
                        (count[THR_W-1:0] >= thresh);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) state <= GATE_WAIT;
      else begin
         unique case (state)
            GATE_WAIT: if (chan_en && reach)  state <= GATE_RUN;
            GATE_RUN:  if (!chan_en || drain) state <= GATE_WAIT;
            default:                          state <= GATE_WAIT;
         endcase
      end
   end

   assign run = (state == GATE_RUN);
endmodule

// File: rtl/pgate_frame.sv
// Per-frame arrival tally with sticky mismatch flag.
module pgate_frame #(
   parameter int FRM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arrive,
   input  logic             frame_start,
   input  logic [FRM_W-1:0] expect_cnt,
   output logic             err
);
   localparam logic [FRM_W-1:0] FRM_MAX = {FRM_W{1'b1}};
   localparam logic [FRM_W-1:0] FRM_ONE = {{(FRM_W-1){1'b0}}, 1'b1};

   logic [FRM_W-1:0] tally;
   logic             opened;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tally  <= '0;
         opened <= 1'b0;
         err    <= 1'b0;
      end else if (frame_start) begin
         if (opened && (tally != expect_cnt)) err <= 1'b1;
         opened <= 1'b1;
         tally  <= arrive ? FRM_ONE : '0;
      end else if (arrive && (tally != FRM_MAX)) begin
         tally <= tally + FRM_ONE;
      end
   end
endmodule

// File: rtl/pgate_top.sv
module pgate_top #(
   parameter int CNT_W = 16,
   parameter int THR_W = 32,
   parameter int FRM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic [THR_W-1:0] start_thresh,
   input  logic [FRM_W-1:0] frame_expect,
   input  logic             pkt_arrive,
   input  logic             pkt_consume,
   input  logic             frame_start,
   output logic [CNT_W-1:0] buffered,
   output logic             run,
   output logic             frame_err
);
   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt
         $error("pgate_top: CNT_W must be 2..64");
      end
      if (THR_W < 1 || THR_W > 64) begin : g_bad_thr
         $error("pgate_top: THR_W must be 1..64");
      end
      if (FRM_W < 2) begin : g_bad_frm
         $error("pgate_top: FRM_W must be at least 2");
      end
   endgenerate

   logic honoured_dec;
   logic drain;

   assign honoured_dec = pkt_consume && run;

   pgate_occ #(.CNT_W(CNT_W)) u_occ (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (pkt_arrive),
      .dec   (honoured_dec),
      .count (buffered),
      .drain (drain)
   );

   pgate_fsm #(.CNT_W(CNT_W), .THR_W(THR_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .chan_en (chan_en),
      .thresh  (start_thresh),
      .count   (buffered),
      .drain   (drain),
      .run     (run)
   );

   pgate_frame #(.FRM_W(FRM_W)) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .arrive      (pkt_arrive),
      .frame_start (frame_start),
      .expect_cnt  (frame_expect),
      .err         (frame_err)
   );
endmodule

// File: rtl/pgate_chk.sv
module pgate_chk #(
   parameter int CNT_W = 16,
   parameter int THR_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chan_en,
   input logic [THR_W-1:0] start_thresh,
   input logic             pkt_arrive,
   input logic             pkt_consume,
   input logic [CNT_W-1:0] buffered,
   input logic             run,
   input logic             frame_err
);
   localparam logic [CNT_W-1:0] ONE_C = {{(CNT_W-1){1'b0}}, 1'b1};

   AST_ARRIVE_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_arrive && !(pkt_consume && run) && (buffered != {CNT_W{1'b1}}))
      |=> (buffered == $past(buffered) + ONE_C)); // R2

   AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_arrive && pkt_consume && run) |=> $stable(buffered)); // R4

   AST_WAIT_IGNORES_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !pkt_arrive) |=> $stable(buffered)); // R5

   AST_RELEASE_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> ($past(chan_en) &&
                      ($past(64'(buffered)) >= $past(64'(start_thresh))))); // R3

   AST_DRAIN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (run && pkt_consume && !pkt_arrive && (buffered == ONE_C)) |=> !run); // R6

   AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_en && run) |=> !run); // R7

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err); // R9
endmodule

bind pgate_top pgate_chk #(.CNT_W(CNT_W), .THR_W(THR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .chan_en      (chan_en),
   .start_thresh (start_thresh),
   .pkt_arrive   (pkt_arrive),
   .pkt_consume  (pkt_consume),
   .buffered     (buffered),
   .run          (run),
   .frame_err    (frame_err)
);

// File: tb/tb_pgate_top.sv
`timescale 1ns/1ps
module tb_pgate_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_en = 1'b0;
   logic [31:0] start_thresh = '0;
   logic [15:0] frame_expect = '0;
   logic        pkt_arrive = 1'b0;
   logic        pkt_consume = 1'b0;
   logic        frame_start = 1'b0;
   logic [15:0] buffered;
   logic        run;
   logic        frame_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   pgate_top dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
      .start_thresh(start_thresh), .frame_expect(frame_expect),
      .pkt_arrive(pkt_arrive), .pkt_consume(pkt_consume),
      .frame_start(frame_start), .buffered(buffered),
      .run(run), .frame_err(frame_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive one cycle of pulses from a falling edge, return at the next falling edge.
   task automatic cyc(input logic a, input logic c, input logic f);
      pkt_arrive = a; pkt_consume = c; frame_start = f;
      @(negedge clk);
      pkt_arrive = 1'b0; pkt_consume = 1'b0; frame_start = 1'b0;
   endtask

   task automatic do_reset();
      chan_en = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
   endtask

   initial begin
      #(5.0 * 190000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      chk("R1 buffered", 32'(buffered), 0);
      chk("R1 run", 32'(run), 0);
      chk("R1 frame_err", 32'(frame_err), 0);

      // Threshold sweep: release timing, drain and refill (R3, R2, R6)
      for (int t = 0; t <= 8; t++) begin
         do_reset();
         start_thresh = 32'(t);
         chan_en = 1'b1;
         cyc(0, 0, 0);
         chk("R3 release on enable", 32'(run), 32'(t == 0));
         for (int i = 1; i <= t + 1; i++) begin
            cyc(1, 0, 0);
            chk("R2 count up", 32'(buffered), 32'(i));
            chk("R3 run timing", 32'(run), 32'((i - 1) >= t));
         end
         cyc(0, 0, 0);
         chk("R3 run after level", 32'(run), 1);
         for (int j = 1; j <= t + 1; j++) begin
            cyc(0, 1, 0);
            chk("R2 count down", 32'(buffered), 32'(t + 1 - j));
            chk("R6 run while draining", 32'(run), 32'(j != t + 1));
         end
         cyc(0, 0, 0);
         chk("R6 wait after drain", 32'(run), 32'(t == 0));
         if (t >= 2) begin
            cyc(1, 0, 0);
            cyc(0, 0, 0);
            chk("R6 refill below level", 32'(run), 0);
         end
      end

      // Ignored consumption and paired pulses while waiting (R5, R4)
      do_reset();
      start_thresh = 32'd5;
      chan_en = 1'b1;
      cyc(1, 0, 0);
      cyc(1, 0, 0);
      cyc(0, 1, 0);
      chk("R5 consume ignored", 32'(buffered), 2);
      cyc(1, 1, 0);
      chk("R5 pair while waiting counts arrival", 32'(buffered), 3);
      cyc(1, 0, 0);
      cyc(1, 0, 0);
      cyc(0, 0, 0);
      chk("R3 run at five", 32'(run), 1);
      cyc(1, 1, 0);
      chk("R4 pair while running", 32'(buffered), 5);

      // Disable while running (R7)
      chan_en = 1'b0;
      cyc(0, 0, 0);
      chk("R7 run cleared", 32'(run), 0);
      chk("R7 count kept", 32'(buffered), 5);
      cyc(0, 1, 0);
      chk("R7 consume ignored when disabled", 32'(buffered), 5);

      // Upper threshold bits matter (R3)
      do_reset();
      start_thresh = 32'h0001_0002;
      chan_en = 1'b1;
      for (int i = 0; i < 4; i++) cyc(1, 0, 0);
      cyc(0, 0, 0);
      chk("R3 wide threshold holds", 32'(run), 0);

      // Saturation at 0 while running with zero threshold (R2)
      do_reset();
      start_thresh = 32'd0;
      chan_en = 1'b1;
      cyc(0, 0, 0);
      cyc(0, 1, 0);
      chk("R2 floor at zero", 32'(buffered), 0);

      // Saturation at top (R2)
      do_reset();
      start_thresh = 32'hFFFF_FFFF;
      chan_en = 1'b1;
      for (int i = 0; i < 65536; i++) cyc(1, 0, 0);
      chk("R2 ceiling", 32'(buffered), 32'hFFFF);
      chk("R3 no release under huge threshold", 32'(run), 0);

      // Frame checking sweep (R8)
      for (int e = 0; e < 4; e++) begin
         for (int n = 0; n < 4; n++) begin
            do_reset();
            frame_expect = 16'(e);
            cyc(0, 0, 1);
            for (int k = 0; k < n; k++) cyc(1, 0, 0);
            cyc(0, 0, 1);
            chk("R8 frame compare", 32'(frame_err), 32'(n != e));
         end
      end

      // Directed frame sequence (R8, R9, R1)
      do_reset();
      frame_expect = 16'd3;
      cyc(1, 0, 0);
      cyc(1, 0, 0);
      cyc(0, 0, 1);
      chk("R8 first frame unchecked", 32'(frame_err), 0);
      cyc(1, 0, 0);
      cyc(1, 0, 0);
      cyc(1, 0, 0);
      cyc(1, 0, 1);
      chk("R8 exact frame", 32'(frame_err), 0);
      cyc(1, 0, 0);
      cyc(1, 0, 0);
      cyc(0, 0, 1);
      chk("R8 coincident arrival joins new frame", 32'(frame_err), 0);
      cyc(1, 0, 0);
      cyc(1, 0, 0);
      cyc(0, 0, 1);
      chk("R8 short frame", 32'(frame_err), 1);
      cyc(1, 0, 0);
      cyc(1, 0, 0);
      cyc(1, 0, 0);
      cyc(0, 0, 1);
      chk("R9 error sticky", 32'(frame_err), 1);
      do_reset();
      chk("R9 reset clears error", 32'(frame_err), 0);
      chk("R1 count after reset", 32'(buffered), 0);

      summary();
      $finish;
   end
endmodule